// File: doc/BRIEF.md
# Sync-Gated Serial Receive Buffer

This block collects recovered serial bits into a 16-bit buffer that a host drains one bit per read strobe. Each bit arrives with a one-cycle strobe. The block raises an interrupt once the number of buffered bits reaches a programmable level, so the host knows when to come and read.

Storage can be held off until a fixed two-byte synchronization word has gone past on the serial stream. Every bit after that word counts as payload. A latched valid-data flag tells the host that the word was found. A restart input re-arms the word search for the next frame. Frames are expected to open with one or two bytes of alternating ones and zeros, followed by the sync word.

The buffered bits are presented in parallel and left-justified. The oldest bit sits at the top, and the positions that hold no bit read as zero.

Top module: `rx_sync_fifo`

## Requirements
- R1: During and after reset, `irq` and `data_valid` are low, `rd_data` is all zeros and the buffer holds no bits.
- R2: With gating off, each strobed bit (`bit_vld` high) is appended behind the bits already held. `rd_data[15]` is the oldest bit, and later bits follow towards bit 0. Positions that hold no bit read as 0.
- R3: `irq` is high exactly when the number of held bits is at least `thresh_code + 1`, so codes 0 to 15 select 1 to 16 bits. It drops as soon as the count falls below that level.
- R4: A read strobe on a non-empty buffer removes the oldest bit. `rd_data` shifts up by one, a zero enters at bit 0, and the count falls by one. A read strobe on an empty buffer changes nothing.
- R5: A read strobe and a stored bit in the same cycle remove the oldest bit and append the new one. The count stays the same.
- R6: When 16 bits are held and another bit is stored without a read, the oldest bit is dropped and the new bit enters at bit 0. The count stays at 16.
- R7: With `sync_gate_en` high and no word found, no bit is stored. The word is found when the last 16 strobed bits, taken first-received to last-received as bit 15 down to bit 0, equal 0x2DD4. The bit that completes the word is not stored. The next strobed bit is stored.
- R8: `data_valid` rises in the cycle after the bit that completes the word. It stays high until a restart or reset. The search runs whether or not gating is enabled.
- R9: A `sync_restart` cycle clears `data_valid` and the search history. A bit strobed in that cycle is neither stored nor searched, and held bits are kept. After a restart or reset, a match needs at least 16 new bits.
- R10: A strobed bit or read shows on `rd_data`, `irq` and `data_valid` after exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_vld | input | 1 | Strobe: `bit_dat` carries a received bit this cycle |
| bit_dat | input | 1 | Received serial bit |
| thresh_code | input | 4 | Interrupt level code, level = code + 1 bits |
| sync_gate_en | input | 1 | Store only after the sync word has been found |
| sync_restart | input | 1 | Clear the found state and the search history |
| rd_strb | input | 1 | Host read: remove the oldest held bit |
| irq | output | 1 | Fill level at or above the threshold |
| data_valid | output | 1 | Sync word found since the last restart |
| rd_data | output | 16 | Held bits, oldest at bit 15, zeros below the fill level |

## Verification
A bit arrival and a host read can land in the same cycle, and this happens both when the buffer is partly filled and when it is full. The bench drives both strobes in one cycle at several fill levels. It expects the count to stay unchanged, the oldest bit to be gone and the new bit to sit directly behind the survivors. A bench-side bit queue, updated from the requirements, gives the expected `rd_data` and `irq` after every cycle.

// File: rtl/rxsg_pkg.sv
package rxsg_pkg;
  localparam int unsigned SYNC_W = 16;
  localparam logic [SYNC_W-1:0] SYNC_PATTERN = 16'h2DD4;
endpackage

// File: rtl/rxsg_rst_sync.sv
module rxsg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/rxsg_sync_detect.sv
module rxsg_sync_detect
  import rxsg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_dat,
  input  logic restart,
  output logic found
);
  logic [SYNC_W-1:0] win_q, win_d;
  logic              found_q, found_d;
  logic              hit;
  logic              upd;

  // Window resets to all ones: the pattern MSB is zero, so a match needs 16 real bits.
  always_comb begin
    win_d   = win_q;
    found_d = found_q;
    hit     = 1'b0;
    if (restart) begin
      win_d   = '1;
      found_d = 1'b0;
    end else if (bit_vld) begin
      win_d = {win_q[SYNC_W-2:0], bit_dat};
      hit   = (win_d == SYNC_PATTERN);
      if (hit) found_d = 1'b1;
    end
  end

  assign upd = restart | bit_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q   <= '1;
      found_q <= 1'b0;
    end else if (upd) begin
      win_q   <= win_d;
      found_q <= found_d;
    end
  end

  assign found = found_q;
endmodule

// File: rtl/rxsg_bit_queue.sv
module rxsg_bit_queue #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_bit,
  input  logic             rd_en,
  output logic [CNT_W-1:0] level,
  output logic [DEPTH-1:0] data
);
  logic [DEPTH-1:0] data_q, data_d;
  logic [CNT_W-1:0] level_q, level_d;
  logic             rd_go, full, upd;
  int               wr_idx;

  always_comb begin
    data_d  = data_q;
    level_d = level_q;
    rd_go   = rd_en && (level_q != '0);
    full    = (level_q == CNT_W'(DEPTH));
    wr_idx  = (rd_go ? DEPTH : DEPTH - 1) - int'(level_q);
    if (rd_go) begin
      data_d  = {data_q[DEPTH-2:0], 1'b0};
      level_d = level_q - CNT_W'(1);
    end
    if (wr_en) begin
      if (full && !rd_go) begin
        data_d = {data_q[DEPTH-2:0], wr_bit};
      end else begin
        for (int i = 0; i < DEPTH; i++) begin
          if (i == wr_idx) data_d[i] = wr_bit;
        end
        level_d = level_d + CNT_W'(1);
      end
    end
  end

  assign upd = wr_en | rd_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      level_q <= '0;
    end else if (upd) begin
      data_q  <= data_d;
      level_q <= level_d;
    end
  end

  assign level = level_q;
  assign data  = data_q;
endmodule

// File: rtl/rxsg_level_irq.sv
module rxsg_level_irq #(
  parameter int CNT_W = 5,
  parameter int THR_W = 4
) (
  input  logic [CNT_W-1:0] level,
  input  logic [THR_W-1:0] code,
  output logic             irq
);
  logic [CNT_W-1:0] need;

  always_comb begin
    need = CNT_W'(code) + CNT_W'(1);
    irq  = (level >= need);
  end
endmodule

// File: rtl/rx_sync_fifo.sv
module rx_sync_fifo #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_dat,
  input  logic [THR_W-1:0] thresh_code,
  input  logic             sync_gate_en,
  input  logic             sync_restart,
  input  logic             rd_strb,
  output logic             irq,
  output logic             data_valid,
  output logic [DEPTH-1:0] rd_data
);
  logic             rst_int_n;
  logic             sync_found;
  logic             store_en;
  logic [CNT_W-1:0] fill_lvl;

  rxsg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  rxsg_sync_detect u_det (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .bit_vld (bit_vld),
    .bit_dat (bit_dat),
    .restart (sync_restart),
    .found   (sync_found)
  );

  assign store_en = bit_vld && !sync_restart && (!sync_gate_en || sync_found);

  rxsg_bit_queue #(.DEPTH(DEPTH)) u_q (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (store_en),
    .wr_bit (bit_dat),
    .rd_en  (rd_strb),
    .level  (fill_lvl),
    .data   (rd_data)
  );

  rxsg_level_irq #(.CNT_W(CNT_W), .THR_W(THR_W)) u_irq (
    .level (fill_lvl),
    .code  (thresh_code),
    .irq   (irq)
  );

  assign data_valid = sync_found;
endmodule

// File: rtl/rxsg_chk.sv
module rxsg_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr,
  input logic             rd_strb,
  input logic             sync_gate_en,
  input logic             sync_restart,
  input logic             data_valid,
  input logic             irq,
  input logic [CNT_W-1:0] fill
);
  // R8
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid && !sync_restart |=> data_valid);
  // R9
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_restart |=> !data_valid);
  // R4
  read_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strb && (fill != '0) && !wr |=> fill == $past(fill) - CNT_W'(1));
  // R2
  write_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr && !rd_strb && (fill != CNT_W'(DEPTH)) |=> fill == $past(fill) + CNT_W'(1));
  // R5
  both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr && rd_strb && (fill != '0) |=> $stable(fill));
  // R7
  gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_gate_en && !data_valid && !rd_strb |=> fill >= $past(fill) && !(fill > $past(fill)));
  // R3
  empty_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0) |-> !irq);
  // R6
  fill_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));
endmodule

bind rx_sync_fifo rxsg_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .wr           (store_en),
  .rd_strb      (rd_strb),
  .sync_gate_en (sync_gate_en),
  .sync_restart (sync_restart),
  .data_valid   (data_valid),
  .irq          (irq),
  .fill         (fill_lvl)
);

// File: tb/rx_sync_fifo_bench.sv
module rx_sync_fifo_bench;
  logic        clk;
  logic        rst_n;
  logic        bit_vld, bit_dat, sync_gate_en, sync_restart, rd_strb;
  logic [3:0]  thresh_code;
  logic        irq, data_valid;
  logic [15:0] rd_data;

  int n_run, n_fail;
  bit done;

  // bench model, built from the requirements
  bit          mq[$];
  logic [15:0] m_win;
  bit          m_found;

  rx_sync_fifo u_rx_sync_fifo (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_dat(bit_dat),
    .thresh_code(thresh_code), .sync_gate_en(sync_gate_en),
    .sync_restart(sync_restart), .rd_strb(rd_strb),
    .irq(irq), .data_valid(data_valid), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] exp_data();
    logic [15:0] e = '0;
    for (int i = 0; i < mq.size(); i++) e[15-i] = mq[i];
    return e;
  endfunction

  task automatic check(string tag);
    logic [15:0] ed = exp_data();
    bit ei = (mq.size() >= int'(thresh_code) + 1);
    n_run++;
    if (rd_data !== ed || irq !== ei || data_valid !== m_found) begin
      n_fail++;
      $display("FAIL %s: rd_data=%h irq=%b valid=%b expected rd_data=%h irq=%b valid=%b",
               tag, rd_data, irq, data_valid, ed, ei, m_found);
    end
  endtask

  // one clock: drive at a falling edge, step the model, return at the next falling edge
  task automatic cyc(bit v, bit d, bit r, bit s);
    bit wr;
    bit rdok;
    bit_vld = v; bit_dat = d; rd_strb = r; sync_restart = s;
    wr   = v && !s && (!sync_gate_en || m_found);
    rdok = r && (mq.size() > 0);
    if (rdok) void'(mq.pop_front());
    if (wr) begin
      if (mq.size() == 16) void'(mq.pop_front());
      mq.push_back(d);
    end
    if (s) begin
      m_win = '1; m_found = 1'b0;
    end else if (v) begin
      m_win = {m_win[14:0], d};
      if (m_win == 16'h2DD4) m_found = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    bit_vld = 0; rd_strb = 0; sync_restart = 0;
  endtask

  task automatic send_byte(logic [7:0] b, string tag);
    for (int i = 7; i >= 0; i--) begin
      cyc(1'b1, b[i], 1'b0, 1'b0);
      check(tag);
    end
  endtask

  task automatic drain(string tag);
    while (mq.size() > 0) cyc(1'b0, 1'b0, 1'b1, 1'b0);
    check(tag);
  endtask

  task automatic t_reset();
    rst_n = 0; bit_vld = 0; bit_dat = 0; rd_strb = 0; sync_restart = 0;
    sync_gate_en = 0; thresh_code = 4'd7;
    mq.delete(); m_win = '1; m_found = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 after reset");
  endtask

  task automatic t_plain();
    thresh_code = 4'd7;
    send_byte(8'hB3, "R2 R10 R3 ungated fill");
    send_byte(8'h4E, "R2 ungated second byte");
  endtask

  task automatic t_threshold();
    drain("R4 drain");
    thresh_code = 4'd0; check("R3 code0 empty");
    cyc(1, 1, 0, 0);    check("R3 code0 one bit");
    thresh_code = 4'd15;
    for (int i = 0; i < 14; i++) begin cyc(1, i[0], 0, 0); check("R3 code15 below"); end
    cyc(1, 0, 0, 0);    check("R3 code15 at 16");
    cyc(0, 0, 1, 0);    check("R3 code15 drop");
    thresh_code = 4'd7;
  endtask

  task automatic t_read();
    for (int i = 0; i < 3; i++) begin cyc(0, 0, 1, 0); check("R4 read oldest"); end
    drain("R4 drain all");
    cyc(0, 0, 1, 0);    check("R4 empty read ignored");
  endtask

  task automatic t_both();
    send_byte(8'hC5, "R2 refill");
    cyc(1, 0, 1, 0);    check("R5 read+write partial");
    cyc(1, 1, 1, 0);    check("R5 read+write partial 2");
    drain("R4 drain");
    cyc(1, 1, 1, 0);    check("R5 read on empty with write");
  endtask

  task automatic t_full();
    drain("R4 drain");
    send_byte(8'hF0, "R2 fill a");
    send_byte(8'h0F, "R2 fill b");
    cyc(1, 1, 0, 0);    check("R6 overflow drops oldest");
    cyc(1, 0, 0, 0);    check("R6 overflow again");
    cyc(1, 1, 1, 0);    check("R5 read+write when full");
    drain("R4 drain");
  endtask

  task automatic t_gate();
    sync_gate_en = 1;
    cyc(0, 0, 0, 1);    check("R9 restart clears");
    send_byte(8'hAA, "R7 preamble not stored");
    send_byte(8'h2D, "R7 sync hi not stored");
    send_byte(8'hD5, "R7 near miss not stored");
    cyc(0, 0, 0, 1);    check("R9 restart");
    send_byte(8'h55, "R7 preamble");
    send_byte(8'h2D, "R7 sync hi");
    send_byte(8'hD4, "R8 valid after completing bit");
    send_byte(8'h96, "R7 payload stored");
    send_byte(8'h2D, "R7 payload stored 2");
  endtask

  task automatic t_restart();
    cyc(1, 1, 0, 1);    check("R9 restart bit ignored, data kept");
    // 14 tail bits of the word after a restart must not match
    for (int i = 13; i >= 0; i--) begin
      logic [15:0] w = 16'h2DD4;
      cyc(1, w[i], 0, 0);
      check("R9 short word after restart");
    end
    drain("R4 drain");
    sync_gate_en = 0;
    cyc(0, 0, 0, 1);    check("R9 restart ungated");
    send_byte(8'h2D, "R8 ungated search");
    send_byte(8'hD4, "R8 ungated valid, all stored");
    cyc(1, 0, 1, 0);    check("R8 valid holds");
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    t_reset();
    t_plain();
    t_threshold();
    t_read();
    t_both();
    t_full();
    t_gate();
    t_restart();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule